// File: doc/BRIEF.md
# Compare Timer with Prescaler and Snapshot Read

This block is a 32-bit memory-mapped timer. It counts enable pulses from one of two tick sources: a fast tick, or a fixed slow tick of about 32 kHz. The selected tick can be divided by a power of two, or it can skip the divider. Each resulting count event advances a counter.

When the counter has reached the programmed compare value, the next count event raises a sticky compare flag. That flag can drive a level interrupt. On that same event the counter either restarts from zero or keeps counting through the compare value, depending on a free-run setting.

Software reaches four 32-bit registers through a single-cycle write strobe and a combinational read path. Configuration is locked while the timer is enabled. The counter is read in two steps: a write to the counter address captures the live count into a snapshot, and a read of that address returns the snapshot. Both tick sources are modelled as clock enables in one clock domain.

Top module: `lp_cmp_timer`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control), 0x4 (divider setup), 0x8 (compare) and 0xC (counter snapshot). Accesses with address bits [1:0] not zero write nothing and read 0. After reset every register reads 0, `irq_o` is low, and unused bits always read 0.
- R2: The control register fields are: bit 0 enable, bit 1 mode (stored and read back, with no effect on counting), bit 2 free-run, bit 6 interrupt enable, and bit 7 compare flag. The flag is cleared by writing 1 to bit 7; writing 0 to bit 7 leaves it unchanged.
- R3: Divider-setup bits [1:0] pick the tick source: 0 selects `fast_tick_i`, 2 selects `slow_tick_i`, and 1 or 3 select no source, so the timer does not count.
- R4: With divider-setup bit 2 set, every selected tick is one count event. With bit 2 clear, bits [6:3] hold a value p and one count event occurs every 2^(p+1) selected ticks.
- R5: The compare flag is set by the first count event that occurs while the counter already equals the compare value, not by the event that makes them equal.
- R6: With free-run clear, the count event that sets the flag also returns the counter to 0.
- R7: With free-run set, the counter increments on every count event, including the one that sets the flag, and wraps modulo 2^32.
- R8: `irq_o` is high exactly while the flag and the interrupt enable are both set. It stays high until software clears the flag. A flag-set event in the same cycle as a clear write leaves the flag set.
- R9: While the timer is enabled, writes to the compare register, to the divider-setup register, and to control bits 1 and 2 are ignored. Enable, interrupt enable and flag clear still take effect.
- R10: While enable is clear, the counter and the divider are held at 0. Counting starts from 0 after the next enable.
- R11: Any write to offset 0xC copies the live counter into the snapshot. Reads of 0xC return that snapshot until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick_i | input | 1 | Fast tick enable, one cycle per tick |
| slow_tick_i | input | 1 | Slow (about 32 kHz) tick enable, one cycle per tick |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The assertions check the following on every cycle:
- every rise of the flag is preceded by a count event on a matching counter;
- the counter restarts or increments correctly on that event;
- the counter and divider are cleared while disabled;
- locked registers stay stable under writes while enabled;
- the snapshot equals the count that was live when it was captured;
- the interrupt persists until a control write.

Only the bench scenarios can show the end-to-end results: that the tick source and divider ratio give the right count after a given number of ticks, that write-1-to-clear works through the bus, and that ignored writes leave readable state unchanged. A bench model also follows random mixes of configuration writes, captures and tick patterns.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int DATA_W = 32;
    localparam int PVAL_W = 4;

    // Word index taken from address bits [3:2]
    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_PSR = 2'd1,
        REG_CMP = 2'd2,
        REG_CNT = 2'd3
    } reg_e;

    localparam int CTL_EN   = 0;
    localparam int CTL_MODE = 1;
    localparam int CTL_FRUN = 2;
    localparam int CTL_IE   = 6;
    localparam int CTL_FLAG = 7;

    localparam logic [1:0] SRC_FAST = 2'd0;
    localparam logic [1:0] SRC_SLOW = 2'd2;

    typedef struct packed {
        logic ie;
        logic frun;
        logic mode;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [PVAL_W-1:0] pval;
        logic              byp;
        logic [1:0]        src;
    } psr_t;

    localparam int PSR_W = $bits(psr_t);

    function automatic logic [DATA_W-1:0] pack_ctl(ctl_t c, logic flag);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_EN]   = c.en;
        w[CTL_MODE] = c.mode;
        w[CTL_FRUN] = c.frun;
        w[CTL_IE]   = c.ie;
        w[CTL_FLAG] = flag;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_psr(psr_t p);
        return DATA_W'(p);
    endfunction

    function automatic psr_t unpack_psr(logic [DATA_W-1:0] w);
        return psr_t'(w[PSR_W-1:0]);
    endfunction

endpackage

// File: rtl/lpt_prescale.sv
module lpt_prescale
    import lpt_pkg::*;
#(
    parameter int PV_W = PVAL_W
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  psr_t psr_i,
    input  logic fast_tick_i,
    input  logic slow_tick_i,
    output logic cnt_ev_o
);
    localparam int DIV_W = 1 << PV_W;
    localparam int SH_W  = PV_W + 1;

    logic             tick_sel;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic [SH_W-1:0]  shamt;

    always_comb begin
        unique case (psr_i.src)
            SRC_FAST: tick_sel = fast_tick_i;
            SRC_SLOW: tick_sel = slow_tick_i;
            default:  tick_sel = 1'b0;
        endcase
    end

    // Last divider state before wrap: 2^(p+1) - 1
    assign shamt   = {1'b0, psr_i.pval} + SH_W'(1);
    assign div_lim = ~({DIV_W{1'b1}} << shamt);

    assign cnt_ev_o = en_i & tick_sel & (psr_i.byp | (div_q == div_lim));

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            div_q <= '0;
        end else if (tick_sel && !psr_i.byp) begin
            div_q <= (div_q == div_lim) ? '0 : div_q + DIV_W'(1);
        end
    end

    // R10
    div_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> div_q == '0);

endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             frun_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             cnt_ev_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             match;

    assign match = (cnt_q == cmp_i);
    assign hit_o = en_i & cnt_ev_i & match;
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_ev_i) begin
            cnt_q <= (match && !frun_i) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        en_i && cnt_ev_i && !frun_i && cnt_q == cmp_i |=> cnt_q == '0);

    // R7
    frun_inc_chk: assert property (@(posedge clk) disable iff (rst)
        en_i && cnt_ev_i && frun_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> cnt_q == '0);

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [3:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              flag_set_i,
    input  logic [CNT_W-1:0]  live_cnt_i,
    output ctl_t              ctl_o,
    output psr_t              psr_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] rdata_o
);
    ctl_t             ctl_q;
    psr_t             psr_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] snap_q;
    logic             flag_q;
    logic             aligned;
    reg_e             sel;
    logic             wr_ctl, wr_psr, wr_cmp, wr_cnt;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign sel     = reg_e'(addr_i[3:2]);
    assign wr_ctl  = we_i && aligned && sel == REG_CTL;
    assign wr_psr  = we_i && aligned && sel == REG_PSR;
    assign wr_cmp  = we_i && aligned && sel == REG_CMP;
    assign wr_cnt  = we_i && aligned && sel == REG_CNT;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            psr_q  <= '0;
            cmp_q  <= '0;
            snap_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (flag_set_i) begin
                flag_q <= 1'b1;
            end else if (wr_ctl && wdata_i[CTL_FLAG]) begin
                flag_q <= 1'b0;
            end
            if (wr_ctl) begin
                ctl_q.en <= wdata_i[CTL_EN];
                ctl_q.ie <= wdata_i[CTL_IE];
                if (!ctl_q.en) begin
                    ctl_q.frun <= wdata_i[CTL_FRUN];
                    ctl_q.mode <= wdata_i[CTL_MODE];
                end
            end
            if (wr_psr && !ctl_q.en) begin
                psr_q <= unpack_psr(wdata_i);
            end
            if (wr_cmp && !ctl_q.en) begin
                cmp_q <= wdata_i[CNT_W-1:0];
            end
            if (wr_cnt) begin
                snap_q <= live_cnt_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            unique case (sel)
                REG_CTL: rdata_o = pack_ctl(ctl_q, flag_q);
                REG_PSR: rdata_o = pack_psr(psr_q);
                REG_CMP: rdata_o = DATA_W'(cmp_q);
                REG_CNT: rdata_o = DATA_W'(snap_q);
                default: rdata_o = '0;
            endcase
        end
    end

    assign ctl_o  = ctl_q;
    assign psr_o  = psr_q;
    assign cmp_o  = cmp_q;
    assign flag_o = flag_q;

    // R9
    cmp_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.en && wr_cmp |=> $stable(cmp_q));

    // R9
    psr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.en && wr_psr |=> $stable(psr_q));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.en && wr_ctl |=> $stable(ctl_q.frun) && $stable(ctl_q.mode));

    // R11
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> snap_q == $past(live_cnt_i));

    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set_i |=> flag_q);

endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer
    import lpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fast_tick_i,
    input  logic        slow_tick_i,
    input  logic        bus_we_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o
);
    ctl_t             ctl;
    psr_t             psr;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic             cnt_ev;
    logic             hit;
    logic             flag;

    lpt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (bus_we_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .flag_set_i (hit),
        .live_cnt_i (cnt),
        .ctl_o      (ctl),
        .psr_o      (psr),
        .cmp_o      (cmp),
        .flag_o     (flag),
        .rdata_o    (bus_rdata_o)
    );

    lpt_prescale #(.PV_W(PVAL_W)) u_prescale (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctl.en),
        .psr_i       (psr),
        .fast_tick_i (fast_tick_i),
        .slow_tick_i (slow_tick_i),
        .cnt_ev_o    (cnt_ev)
    );

    lpt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .en_i     (ctl.en),
        .frun_i   (ctl.frun),
        .cmp_i    (cmp),
        .cnt_ev_i (cnt_ev),
        .cnt_o    (cnt),
        .hit_o    (hit)
    );

    assign irq_o = flag & ctl.ie;

    // R5
    flag_after_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ctl.en && cnt_ev && cnt == cmp));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o && !(bus_we_i && bus_addr_i == 4'h0) |=> irq_o);

endmodule

// File: tb/test_lp_cmp_timer.sv
module test_lp_cmp_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ft = 1'b0, st = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    lp_cmp_timer i_lp_cmp_timer (
        .clk(clk), .rst(rst), .fast_tick_i(ft), .slow_tick_i(st),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    // Reference model, built from the requirements
    logic        m_en, m_mode, m_frun, m_ie, m_flag, m_byp;
    logic [3:0]  m_p;
    logic [1:0]  m_src;
    logic [31:0] m_cmp, m_cnt, m_snap, m_div;

    always @(posedge clk) begin
        logic tk, ev, setf;
        logic [31:0] lim, ncnt, ndiv;
        if (rst) begin
            {m_en, m_mode, m_frun, m_ie, m_flag, m_byp} = '0;
            m_p = 0; m_src = 0; m_cmp = 0; m_cnt = 0; m_snap = 0; m_div = 0;
        end else begin
            tk   = (m_src == 0) ? ft : (m_src == 2) ? st : 1'b0;
            lim  = (32'd1 << (m_p + 1)) - 1;
            ev   = 0; setf = 0; ncnt = m_cnt; ndiv = m_div;
            if (!m_en) begin
                ncnt = 0; ndiv = 0;
            end else begin
                if (tk) begin
                    if (m_byp) ev = 1;
                    else if (m_div == lim) begin ev = 1; ndiv = 0; end
                    else ndiv = m_div + 1;
                end
                if (ev) begin
                    if (m_cnt == m_cmp) begin
                        setf = 1;
                        ncnt = m_frun ? m_cnt + 1 : 0;
                    end else ncnt = m_cnt + 1;
                end
            end
            if (we && addr == 4'hC) m_snap = m_cnt;
            if (setf) m_flag = 1;
            else if (we && addr == 4'h0 && wdata[7]) m_flag = 0;
            if (we && addr == 4'h4 && !m_en) begin
                m_p = wdata[6:3]; m_byp = wdata[2]; m_src = wdata[1:0];
            end
            if (we && addr == 4'h8 && !m_en) m_cmp = wdata;
            if (we && addr == 4'h0) begin
                if (!m_en) begin m_frun = wdata[2]; m_mode = wdata[1]; end
                m_en = wdata[0]; m_ie = wdata[6];
            end
            m_cnt = ncnt; m_div = ndiv;
        end
    end

    function automatic logic [31:0] exp_ctl();
        return {24'd0, m_flag, m_ie, 3'd0, m_frun, m_mode, m_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic f, input logic s);
        we = w; addr = a; wdata = d; ft = f; st = s;
        @(posedge clk); @(negedge clk);
        we = 0; ft = 0; st = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, a, d, 0, 0);
    endtask

    task automatic ticks(input int n, input logic f, input logic s);
        for (int i = 0; i < n; i++) cyc(0, 4'h0, 0, f, s);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    task automatic cnt_chk(input string req, input logic [31:0] exp);
        wr(4'hC, 0);
        rd_chk(req, 4'hC, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd_chk("R1 ctl", 4'h0, 0); rd_chk("R1 psr", 4'h4, 0);
        rd_chk("R1 cmp", 4'h8, 0); rd_chk("R1 cnt", 4'hC, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        wr(4'h9, 32'hFF); rd_chk("R1 misaligned", 4'h8, 0);
        // R4 bypass, R5 late flag, R6 restart
        wr(4'h4, 32'h4); wr(4'h8, 5); wr(4'h0, 32'h41);
        ticks(5, 1, 0);
        cnt_chk("R4 bypass count", 5);
        rd_chk("R5 no flag at equality", 4'h0, 32'h41);
        ticks(1, 1, 0);
        rd_chk("R5 flag next count", 4'h0, 32'hC1);
        chk("R8 irq high", {31'd0, irq}, 1);
        cnt_chk("R6 restart at zero", 0);
        wr(4'h0, 32'h41);
        rd_chk("R2 write 0 keeps flag", 4'h0, 32'hC1);
        wr(4'h0, 32'hC1);
        rd_chk("R2 w1c clears flag", 4'h0, 32'h41);
        chk("R8 irq low after clear", {31'd0, irq}, 0);
        // R9 lock while enabled
        wr(4'h8, 9); wr(4'h4, 32'h0); wr(4'h0, 32'h47);
        rd_chk("R9 cmp locked", 4'h8, 5);
        rd_chk("R9 psr locked", 4'h4, 4);
        rd_chk("R9 ctl cfg locked", 4'h0, 32'h41);
        // R10 disable clears
        ticks(2, 1, 0);
        wr(4'h0, 0); ticks(1, 0, 0);
        cnt_chk("R10 disable clears", 0);
        // R7 free-run, R2 mode bit stored
        wr(4'h8, 3); wr(4'h0, 32'h06);
        rd_chk("R2 mode stored", 4'h0, 32'h06);
        wr(4'h0, 32'h07);
        ticks(4, 1, 0);
        cnt_chk("R7 past compare", 4);
        rd_chk("R7 flag set", 4'h0, 32'h87);
        ticks(2, 1, 0);
        cnt_chk("R7 keeps counting", 6);
        // R11 snapshot holds
        ticks(3, 1, 0);
        rd_chk("R11 snapshot held", 4'hC, 6);
        // R3 slow source
        wr(4'h0, 32'h80); ticks(1, 0, 0);
        wr(4'h4, 32'h6); wr(4'h8, 100); wr(4'h0, 1);
        ticks(3, 1, 0);
        cnt_chk("R3 fast ignored", 0);
        ticks(3, 0, 1);
        cnt_chk("R3 slow counted", 3);
        wr(4'h0, 0); wr(4'h4, 32'h5); wr(4'h0, 1);
        ticks(4, 1, 1);
        cnt_chk("R3 source 1 idle", 0);
        // R4 divide by 4
        wr(4'h0, 0); wr(4'h4, 32'h08); wr(4'h0, 1);
        ticks(7, 1, 0);
        cnt_chk("R4 div4 after 7", 1);
        ticks(1, 1, 0);
        cnt_chk("R4 div4 after 8", 2);
        // Random mix against the model
        for (int it = 0; it < 3000; it++) begin
            int r;
            r = $urandom % 10;
            if (r < 2) begin
                logic [1:0] w;
                logic [31:0] d;
                w = 2'($urandom);
                case (w)
                    2'd0: d = {24'd0, 8'($urandom)};
                    2'd1: d = {25'd0, 4'($urandom % 3), 3'($urandom)};
                    2'd2: d = $urandom % 12;
                    default: d = $urandom;
                endcase
                cyc(1, {w, 2'b00}, d, 1'($urandom), 1'($urandom));
            end else begin
                cyc(0, 4'h0, 0, 1'($urandom), 1'($urandom));
            end
            if (it % 16 == 15) begin
                rd_chk("R2 R5 R8 rand ctl", 4'h0, exp_ctl());
                rd_chk("R3 R9 rand psr", 4'h4, {25'd0, m_p, m_byp, m_src});
                rd_chk("R9 rand cmp", 4'h8, m_cmp);
                cnt_chk("R4 R6 R7 R10 R11 rand cnt", m_cnt);
                chk("R8 rand irq", {31'd0, irq}, {31'd0, m_flag & m_ie});
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule